// File: doc/BRIEF.md
# Strobe-Reload Watchdog Timer

This block is a watchdog timer that counts ticks of a slow time base of about 32 Hz. One tick is 31.25 ms. Software programs a 6-bit timeout through a control register. The same register holds two more bits:

- a window bit, which guards the timeout field;
- a strobe bit, which restarts the count without changing the timeout.

If software does not strobe in time, the count runs out. The block then raises a sticky watchdog flag and reloads itself, so that a later timeout is also caught. When the interrupt enable is set, the flag is also presented on a shared interrupt request line. Reading the flags register clears the flag.

The time base enters as a level signal that is synchronous to the system clock. Each rising edge of that signal is one tick. The timeout field counts in ticks: a value N fires after N ticks, up to 63 ticks (about 2 s). A value of zero stops the timer. A new timeout value is used at the next reload (a strobe, an expiry, or a start from the stopped state). It does not change a count that is already running.

Top module: `strobe_watchdog`

## Requirements
- R1: After reset the control readback `rdData` is 0 (timeout 0, window bit 0, so the timer is stopped), and `wdFlag` and `irqReq` are 0.
- R2: A write (`wrEn`=1) with the window bit `wrData[6]` equal to 0 stores `wrData[5:0]` as the timeout. The readback `rdData[5:0]` shows it from the next cycle.
- R3: A write with `wrData[6]`=1 leaves the timeout field unchanged. Every write stores its window bit, which reads back in `rdData[6]`.
- R4: Bit 7 of a write is the strobe, and `rdData[7]` always reads 0.
- R5: A write with the strobe bit set reloads the count from the timeout value in effect after that write. The flag then rises exactly N ticks later, where N is that timeout.
- R6: While the timeout is 0 no tick has any effect, and `wdFlag` never rises.
- R7: When the timeout goes from 0 to N, counting starts by itself. The flag rises on the Nth tick after that, and it is set in the clock cycle that follows the tick's rising edge.
- R8: On expiry the count reloads by itself from the timeout field, so the next expiry comes N ticks later without a strobe.
- R9: Writing a new timeout during a count does not change when the running count expires. The new value governs the count loaded at that expiry.
- R10: A cycle with `flagRead`=1 clears `wdFlag` in the next cycle. If an expiry happens in the same cycle, the flag stays set.
- R11: `irqReq` is 1 exactly while `wdFlag` and `irqEnable` are both 1.
- R12: A tick is the rising edge of `tickIn`. Holding `tickIn` high for many clock cycles counts as one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset (acts as power-up) |
| tickIn | input | 1 | Time base level; each rising edge is one tick |
| irqEnable | input | 1 | Lets the watchdog flag drive the interrupt request |
| wrEn | input | 1 | Write strobe for the control register |
| wrData | input | 8 | Write data: [7] strobe, [6] window, [5:0] timeout |
| flagRead | input | 1 | Flags register is being read; clears the flag |
| rdData | output | 8 | Control readback: [7] 0, [6] window, [5:0] timeout |
| wdFlag | output | 1 | Sticky watchdog expiry flag |
| irqReq | output | 1 | Interrupt request from the watchdog |

## Verification
The bound checker watches the register behaviour on every cycle:

- how a write lands in the timeout field, with or without the window bit;
- the strobe readback;
- that a flag rise only ever follows a tick edge;
- that a flags read clears the flag when no tick edge arrives in the same cycle;
- that a zero timeout keeps the flag low.

How many ticks pass before expiry can only be shown by the bench's scenarios and its cycle-level model. This covers the exact count after a strobe, the automatic reload, a timeout that changes in the middle of a count, one tick for a long-held time base, and a read that meets an expiry in the same cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Strobes issued by the control to the datapath, one cycle at a time.
  typedef struct packed {
    logic takeField;   // latch the written timeout value
    logic takeWindow;  // latch the written window bit
    logic cntClear;    // force the count to zero (timer stopped)
    logic cntLoad;     // load the count from the next timeout value
    logic cntDec;      // decrement the count by one
    logic flagSet;     // expiry: set the watchdog flag
    logic flagClr;     // flags read: clear the watchdog flag
  } wdStrobes_t;

endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int TimeoutWidth = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tickIn,
  input  logic                    wrEn,
  input  logic                    wrStrobe,
  input  logic                    wrWindow,
  input  logic [TimeoutWidth-1:0] wrField,
  input  logic                    flagRead,
  input  logic                    fieldZero,
  input  logic                    cntZero,
  input  logic                    cntOne,
  output wdStrobes_t              st
);

  logic tickQ;
  logic tickEdge;
  logic writesField;
  logic nextFieldZero;

  always_ff @(posedge clk) begin
    if (!rstN) tickQ <= 1'b0;
    else       tickQ <= tickIn;
  end

  assign tickEdge      = tickIn & ~tickQ;
  assign writesField   = wrEn & ~wrWindow;
  assign nextFieldZero = writesField ? (wrField == '0) : fieldZero;

  always_comb begin
    st            = '0;
    st.takeField  = writesField;
    st.takeWindow = wrEn;
    st.flagClr    = flagRead;
    if (nextFieldZero) begin
      st.cntClear = 1'b1;
    end else if ((wrEn && wrStrobe) || cntZero) begin
      st.cntLoad = 1'b1;
    end else if (tickEdge) begin
      if (cntOne) begin
        st.flagSet = 1'b1;
        st.cntLoad = 1'b1;
      end else begin
        st.cntDec = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int TimeoutWidth = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wdStrobes_t              st,
  input  logic                    wrWindow,
  input  logic [TimeoutWidth-1:0] wrField,
  output logic [TimeoutWidth-1:0] field,
  output logic                    window,
  output logic                    flag,
  output logic                    fieldZero,
  output logic                    cntZero,
  output logic                    cntOne
);

  logic [TimeoutWidth-1:0] count;
  logic [TimeoutWidth-1:0] nextField;

  assign nextField = st.takeField ? wrField : field;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      field  <= '0;
      window <= 1'b0;
    end else begin
      if (st.takeField)  field  <= wrField;
      if (st.takeWindow) window <= wrWindow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            count <= '0;
    else if (st.cntClear) count <= '0;
    else if (st.cntLoad)  count <= nextField;
    else if (st.cntDec)   count <= count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           flag <= 1'b0;
    else if (st.flagSet) flag <= 1'b1;
    else if (st.flagClr) flag <= 1'b0;
  end

  assign fieldZero = (field == '0);
  assign cntZero   = (count == '0);
  assign cntOne    = (count == TimeoutWidth'(1));

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
  import wdog_pkg::*;
#(
  parameter int TimeoutWidth = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tickIn,
  input  logic                    irqEnable,
  input  logic                    wrEn,
  input  logic [TimeoutWidth+1:0] wrData,
  input  logic                    flagRead,
  output logic [TimeoutWidth+1:0] rdData,
  output logic                    wdFlag,
  output logic                    irqReq
);

  localparam int StrobeBit = TimeoutWidth + 1;
  localparam int WindowBit = TimeoutWidth;

  wdStrobes_t              st;
  logic [TimeoutWidth-1:0] field;
  logic                    window;
  logic                    fieldZero;
  logic                    cntZero;
  logic                    cntOne;

  wdog_ctrl #(.TimeoutWidth(TimeoutWidth)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickIn   (tickIn),
    .wrEn     (wrEn),
    .wrStrobe (wrData[StrobeBit]),
    .wrWindow (wrData[WindowBit]),
    .wrField  (wrData[TimeoutWidth-1:0]),
    .flagRead (flagRead),
    .fieldZero(fieldZero),
    .cntZero  (cntZero),
    .cntOne   (cntOne),
    .st       (st)
  );

  wdog_datapath #(.TimeoutWidth(TimeoutWidth)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .wrWindow (wrData[WindowBit]),
    .wrField  (wrData[TimeoutWidth-1:0]),
    .field    (field),
    .window   (window),
    .flag     (wdFlag),
    .fieldZero(fieldZero),
    .cntZero  (cntZero),
    .cntOne   (cntOne)
  );

  assign rdData = {1'b0, window, field};
  assign irqReq = wdFlag & irqEnable;

endmodule

// File: rtl/strobe_watchdog_chk.sv
module strobe_watchdog_chk #(
  parameter int TW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          tickIn,
  input logic          wrEn,
  input logic [TW+1:0] wrData,
  input logic          flagRead,
  input logic [TW+1:0] rdData,
  input logic          wdFlag
);

  logic tickQ;
  always_ff @(posedge clk) begin
    if (!rstN) tickQ <= 1'b0;
    else       tickQ <= tickIn;
  end

  // R2: an unguarded write lands in the timeout field
  p_field_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[TW]) |=> (rdData[TW-1:0] == $past(wrData[TW-1:0])));

  // R3: a guarded write keeps the timeout field
  p_field_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[TW]) |=> (rdData[TW-1:0] == $past(rdData[TW-1:0])));

  // R3: the window bit of each write is kept for readback
  p_window_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData[TW] == $past(wrData[TW])));

  // R4: the strobe bit never reads back as set
  p_strobe_reads_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[TW+1]) |=> !rdData[TW+1]);

  // R6: with a zero timeout the flag cannot rise
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((rdData[TW-1:0] == '0) && !wdFlag) |=> !wdFlag);

  // R7: a flag rise always follows a tick rising edge
  p_flag_after_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdFlag) |-> ($past(tickIn) && !$past(tickQ)));

  // R10: a flags read without a coincident tick edge clears the flag
  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    (flagRead && !(tickIn && !tickQ)) |=> !wdFlag);

endmodule

bind strobe_watchdog strobe_watchdog_chk #(.TW(TimeoutWidth)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .tickIn  (tickIn),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .flagRead(flagRead),
  .rdData  (rdData),
  .wdFlag  (wdFlag)
);

// File: tb/strobe_watchdog_tb_top.sv
module strobe_watchdog_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic       irqEnable = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       flagRead = 1'b0;
  logic [7:0] rdData;
  logic       wdFlag;
  logic       irqReq;

  int checks = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  strobe_watchdog dut_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .irqEnable(irqEnable),
    .wrEn(wrEn), .wrData(wrData), .flagRead(flagRead),
    .rdData(rdData), .wdFlag(wdFlag), .irqReq(irqReq)
  );

  task automatic expect_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising clock edge.
  int  mField = 0, mWin = 0, mCnt = 0, mFlag = 0;
  bit  mTickPrev = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mField = 0; mWin = 0; mCnt = 0; mFlag = 0; mTickPrev = 0;
    end else begin
      int  nf;
      bit  fire;
      bit  edgeSeen;
      edgeSeen  = tickIn && !mTickPrev;
      mTickPrev = tickIn;
      nf = mField;
      if (wrEn && !wrData[6]) nf = int'(wrData[5:0]);
      if (wrEn) mWin = int'(wrData[6]);
      fire = 0;
      if (nf == 0) mCnt = 0;
      else if ((wrEn && wrData[7]) || mCnt == 0) mCnt = nf;
      else if (edgeSeen) begin
        if (mCnt == 1) begin fire = 1; mCnt = nf; end
        else mCnt = mCnt - 1;
      end
      mField = nf;
      if (fire) mFlag = 1;
      else if (flagRead) mFlag = 0;
    end
  end

  // Per-cycle comparison, away from both clock edges.
  always begin
    @(negedge clk);
    #5;
    if (rstN && !finished) begin
      expect_eq("R7", "flag vs model", int'(wdFlag), mFlag);
      expect_eq("R11", "irq vs model", int'(irqReq), (mFlag != 0 && irqEnable) ? 1 : 0);
      expect_eq("R2", "readback vs model", int'(rdData), mWin * 64 + mField);
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
    #2;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickIn = 1'b1;
      @(negedge clk); tickIn = 1'b0;
    end
    #2;
  endtask

  task automatic rdFlags();
    @(negedge clk); flagRead = 1'b1;
    @(negedge clk); flagRead = 1'b0;
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    // R1: reset state
    expect_eq("R1", "rdData", int'(rdData), 0);
    expect_eq("R1", "wdFlag", int'(wdFlag), 0);
    expect_eq("R1", "irqReq", int'(irqReq), 0);

    // R2: unguarded write of timeout 5 (also starts counting, R7)
    wr(8'h05);
    expect_eq("R2", "field after write", int'(rdData), 5);
    // R3: guarded write keeps field 5, window reads 1
    wr(8'h7F);
    expect_eq("R3", "guarded write", int'(rdData), 8'h45);
    // R4: strobe bit reads zero
    wr(8'hC0);
    expect_eq("R4", "strobe readback", int'(rdData[7]), 0);
    expect_eq("R4", "field kept", int'(rdData[5:0]), 5);

    // R5: strobe in mid-count restarts a full count
    tick(4);
    expect_eq("R5", "flag before strobe", int'(wdFlag), 0);
    wr(8'hC0);
    tick(4);
    expect_eq("R5", "flag after 4 ticks", int'(wdFlag), 0);
    tick(1);
    expect_eq("R5", "flag after 5 ticks", int'(wdFlag), 1);

    // R11: interrupt gating
    @(negedge clk); irqEnable = 1'b1;
    @(negedge clk); #2;
    expect_eq("R11", "irq enabled", int'(irqReq), 1);
    @(negedge clk); irqEnable = 1'b0;
    @(negedge clk); #2;
    expect_eq("R11", "irq disabled", int'(irqReq), 0);

    // R10: flags read clears
    rdFlags();
    expect_eq("R10", "flag after read", int'(wdFlag), 0);

    // R8: automatic reload after expiry
    tick(4);
    expect_eq("R8", "flag after 4 reload ticks", int'(wdFlag), 0);
    tick(1);
    expect_eq("R8", "flag after 5 reload ticks", int'(wdFlag), 1);
    rdFlags();

    // R9: timeout change during a count
    wr(8'hC0);
    tick(2);
    wr(8'h03);
    tick(2);
    expect_eq("R9", "old count still running", int'(wdFlag), 0);
    tick(1);
    expect_eq("R9", "old count expires", int'(wdFlag), 1);
    rdFlags();
    tick(2);
    expect_eq("R9", "new count not yet", int'(wdFlag), 0);
    tick(1);
    expect_eq("R9", "new count expires", int'(wdFlag), 1);
    rdFlags();

    // R10: read coinciding with expiry keeps flag
    tick(2);
    @(negedge clk); tickIn = 1'b1; flagRead = 1'b1;
    @(negedge clk); tickIn = 1'b0; flagRead = 1'b0;
    #2;
    expect_eq("R10", "set wins over read", int'(wdFlag), 1);
    rdFlags();
    expect_eq("R10", "cleared afterwards", int'(wdFlag), 0);

    // R6: zero timeout stops the timer
    wr(8'h00);
    tick(70);
    expect_eq("R6", "no flag when stopped", int'(wdFlag), 0);

    // R7: start from stopped state
    wr(8'h04);
    tick(3);
    expect_eq("R7", "flag after 3 ticks", int'(wdFlag), 0);
    tick(1);
    expect_eq("R7", "flag after 4 ticks", int'(wdFlag), 1);
    rdFlags();

    // R12: a long-held tick counts once
    wr(8'h02);
    wr(8'hC0);
    @(negedge clk); tickIn = 1'b1;
    repeat (10) @(negedge clk);
    tickIn = 1'b0;
    @(negedge clk); #2;
    expect_eq("R12", "held tick counts once", int'(wdFlag), 0);
    tick(1);
    expect_eq("R12", "second edge expires", int'(wdFlag), 1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule